// File: doc/BRIEF.md
# Crosspoint Bank Write Sequencer

This controller drives a bank of small 8-line by 4-junctor analog crosspoint switch devices that are combined into one larger switch matrix. Every device listens to one shared line-address bus and one shared junctor-data bus. Each device has its own write strobe. All devices share one clear line. A device latches the data bus into the control word picked by the address while its strobe is high. Because of this, the address must settle before the strobe rises, the strobe must last a minimum time, and the data must stay put after the strobe falls.

A write command arrives on a valid/ready handshake and carries three fields: a device index, a line number and a junctor mask. The sequencer then steps through three timed phases (address setup, strobe high, data hold), and each phase length is a parameter in clock cycles. Only one command is in flight at a time. A separate clear request pulses the shared clear line for a parameterized number of cycles. The clear request wins over any write waiting in the same cycle. A command that names a device beyond the bank is refused with a one-cycle error pulse.

Top module: `xpt_write_seq`

## Requirements
- R1: While rst_ni is low, and after it is released with no request pending, cmd_ready_o is 1 and dev_strobe_o, master_rst_o, cmd_err_o, bus_addr_o and bus_data_o are all 0.
- R2: A command is taken on a rising edge where cmd_valid_i and cmd_ready_o are both 1. For an in-range write, cmd_ready_o is then 0 for exactly SETUP_CYC+STROBE_CYC+HOLD_CYC cycles starting in the cycle after that edge.
- R3: From the cycle after an in-range write is taken, bus_addr_o holds the line number in binary and bus_data_o holds the junctor mask (bit j set closes junctor j). Both stay unchanged through the setup and strobe phases.
- R4: After SETUP_CYC setup cycles, only dev_strobe_o bit d (d being the command's device index) goes high, and it stays high for exactly STROBE_CYC cycles. At most one strobe bit is ever high.
- R5: After the strobe falls, bus_addr_o and bus_data_o stay unchanged for HOLD_CYC more cycles. No new command is taken before that hold ends.
- R6: A taken clear request drives master_rst_o high for exactly CLEAR_CYC cycles, starting in the cycle after the edge that took it. During that time no strobe fires and cmd_ready_o is 0.
- R7: While clr_req_i is 1, cmd_ready_o is 0, so a clear that arrives with a pending write is served first. A clear raised during a write starts once that write's hold phase ends.
- R8: A command whose device index is NUM_DEV or above produces cmd_err_o high for exactly the one cycle after it is taken. It fires no strobe, leaves both buses unchanged, and leaves cmd_ready_o high.
- R9: master_rst_o and any dev_strobe_o bit are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_req_i | input | 1 | Clear request, level; taken when idle |
| cmd_valid_i | input | 1 | Write command valid |
| cmd_ready_o | output | 1 | Sequencer can take a write command |
| cmd_dev_i | input | DEV_W | Target device index |
| cmd_line_i | input | LINE_W | Line number within the device |
| cmd_mask_i | input | MASK_W | Junctor mask, bit j for junctor j |
| bus_addr_o | output | LINE_W | Shared line-address bus |
| bus_data_o | output | MASK_W | Shared junctor-data bus |
| dev_strobe_o | output | NUM_DEV | Per-device write strobes |
| master_rst_o | output | 1 | Shared clear line to all devices |
| cmd_err_o | output | 1 | One-cycle pulse for a refused device index |

## Verification
The hardest situation to reach is a clear and a write that contend for the same idle cycle after a write already in flight: the clear must win, and the write must follow once the clear ends. The stimulus gets there by raising the clear request and a second valid write while the first write is still in its setup phase. It holds both until the clear line is seen high, then drops only the clear request. A behavioural model with per-phase countdowns runs beside the design and is compared on every cycle. Back-to-back writes, all-zero and all-one masks, the last legal device index and two out-of-range indices round out the patterns.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_STROBE = 3'd2,
    PH_HOLD   = 3'd3,
    PH_CLEAR  = 3'd4
  } phase_e;
endpackage

// File: rtl/xpt_phase_timer.sv
module xpt_phase_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= load_val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/xpt_seq_fsm.sv
module xpt_seq_fsm
  import xpt_pkg::*;
#(
  parameter int SETUP_CYC  = 2,
  parameter int STROBE_CYC = 3,
  parameter int HOLD_CYC   = 2,
  parameter int CLEAR_CYC  = 4,
  parameter int CNT_W      = 3
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_wr_i,
  input  logic   start_clr_i,
  output phase_e phase_q_o,
  output phase_e phase_d_o,
  output logic   idle_o
);
  phase_e           phase_q, phase_d;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             last;

  xpt_phase_timer #(.CNT_W(CNT_W)) timer_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .last_o     (last)
  );

  always_comb begin
    phase_d  = phase_q;
    load     = 1'b0;
    load_val = '0;
    unique case (phase_q)
      PH_IDLE: begin
        // clear outranks a write in the same cycle
        if (start_clr_i) begin
          phase_d = PH_CLEAR; load = 1'b1; load_val = CNT_W'(CLEAR_CYC);
        end else if (start_wr_i) begin
          phase_d = PH_SETUP; load = 1'b1; load_val = CNT_W'(SETUP_CYC);
        end
      end
      PH_SETUP: if (last) begin
        phase_d = PH_STROBE; load = 1'b1; load_val = CNT_W'(STROBE_CYC);
      end
      PH_STROBE: if (last) begin
        phase_d = PH_HOLD; load = 1'b1; load_val = CNT_W'(HOLD_CYC);
      end
      PH_HOLD:  if (last) phase_d = PH_IDLE;
      PH_CLEAR: if (last) phase_d = PH_IDLE;
      default:  phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_IDLE;
    else         phase_q <= phase_d;
  end

  assign phase_q_o = phase_q;
  assign phase_d_o = phase_d;
  assign idle_o    = (phase_q == PH_IDLE);
endmodule

// File: rtl/xpt_strobe_dec.sv
module xpt_strobe_dec #(
  parameter int NUM_DEV = 4,
  parameter int DEV_W   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [DEV_W-1:0]   dev_i,
  output logic [NUM_DEV-1:0] strobe_o
);
  // registered so a decode glitch never reaches an async-write strobe
  for (genvar g = 0; g < NUM_DEV; g++) begin : g_stb
    logic stb_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stb_q <= 1'b0;
      else         stb_q <= en_i && (dev_i == DEV_W'(g));
    end
    assign strobe_o[g] = stb_q;
  end
endmodule

// File: rtl/xpt_write_seq.sv
module xpt_write_seq
  import xpt_pkg::*;
#(
  parameter int NUM_DEV    = 4,
  parameter int DEV_W      = 3,
  parameter int LINE_W     = 3,
  parameter int MASK_W     = 4,
  parameter int SETUP_CYC  = 2,
  parameter int STROBE_CYC = 3,
  parameter int HOLD_CYC   = 2,
  parameter int CLEAR_CYC  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_req_i,
  input  logic               cmd_valid_i,
  output logic               cmd_ready_o,
  input  logic [DEV_W-1:0]   cmd_dev_i,
  input  logic [LINE_W-1:0]  cmd_line_i,
  input  logic [MASK_W-1:0]  cmd_mask_i,
  output logic [LINE_W-1:0]  bus_addr_o,
  output logic [MASK_W-1:0]  bus_data_o,
  output logic [NUM_DEV-1:0] dev_strobe_o,
  output logic               master_rst_o,
  output logic               cmd_err_o
);
  localparam int MAX_A   = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
  localparam int MAX_B   = (HOLD_CYC > CLEAR_CYC) ? HOLD_CYC : CLEAR_CYC;
  localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [DEV_W:0] DEV_LIMIT = (DEV_W+1)'(NUM_DEV);

  phase_e             phase_q, phase_d;
  logic               idle;
  logic               accept, in_range, start_wr, start_clr;
  logic [DEV_W-1:0]   dev_q;
  logic [LINE_W-1:0]  addr_q;
  logic [MASK_W-1:0]  data_q;
  logic               mrst_q, err_q;

  assign cmd_ready_o = idle && !clr_req_i;
  assign accept      = cmd_valid_i && cmd_ready_o;
  assign in_range    = ({1'b0, cmd_dev_i} < DEV_LIMIT);
  assign start_wr    = accept && in_range;
  assign start_clr   = idle && clr_req_i;

  xpt_seq_fsm #(
    .SETUP_CYC  (SETUP_CYC),
    .STROBE_CYC (STROBE_CYC),
    .HOLD_CYC   (HOLD_CYC),
    .CLEAR_CYC  (CLEAR_CYC),
    .CNT_W      (CNT_W)
  ) fsm_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_wr_i  (start_wr),
    .start_clr_i (start_clr),
    .phase_q_o   (phase_q),
    .phase_d_o   (phase_d),
    .idle_o      (idle)
  );

  // bus registers load only on an accepted in-range write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dev_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else if (start_wr) begin
      dev_q  <= cmd_dev_i;
      addr_q <= cmd_line_i;
      data_q <= cmd_mask_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mrst_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      mrst_q <= (phase_d == PH_CLEAR);
      err_q  <= accept && !in_range;
    end
  end

  xpt_strobe_dec #(.NUM_DEV(NUM_DEV), .DEV_W(DEV_W)) dec_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (phase_d == PH_STROBE),
    .dev_i    (dev_q),
    .strobe_o (dev_strobe_o)
  );

  assign bus_addr_o   = addr_q;
  assign bus_data_o   = data_q;
  assign master_rst_o = mrst_q;
  assign cmd_err_o    = err_q;

  logic unused_phase;
  assign unused_phase = ^phase_q;
endmodule

// File: rtl/xpt_write_seq_chk.sv
module xpt_write_seq_chk #(
  parameter int NUM_DEV    = 4,
  parameter int DEV_W      = 3,
  parameter int LINE_W     = 3,
  parameter int MASK_W     = 4,
  parameter int STROBE_CYC = 3,
  parameter int CLEAR_CYC  = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               clr_req_i,
  input logic               cmd_valid_i,
  input logic               cmd_ready_o,
  input logic [DEV_W-1:0]   cmd_dev_i,
  input logic [LINE_W-1:0]  bus_addr_o,
  input logic [MASK_W-1:0]  bus_data_o,
  input logic [NUM_DEV-1:0] dev_strobe_o,
  input logic               master_rst_o,
  input logic               cmd_err_o
);
  logic        any_stb;
  logic [15:0] stb_cnt, rst_cnt;
  assign any_stb = |dev_strobe_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_cnt <= '0;
      rst_cnt <= '0;
    end else begin
      stb_cnt <= any_stb ? stb_cnt + 1'b1 : '0;
      rst_cnt <= master_rst_o ? rst_cnt + 1'b1 : '0;
    end
  end

  assert_strobe_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dev_strobe_o));
  assert_strobe_width_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(any_stb) |-> (stb_cnt == 16'(STROBE_CYC)));
  assert_busy_during_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_stb |-> !cmd_ready_o);
  assert_bus_steady_strobe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_stb |-> ($stable(bus_addr_o) && $stable(bus_data_o)));
  assert_bus_steady_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(any_stb) |-> ($stable(bus_addr_o) && $stable(bus_data_o) && !cmd_ready_o));
  assert_clear_width_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(master_rst_o) |-> (rst_cnt == 16'(CLEAR_CYC)));
  assert_clear_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_rst_o |-> !cmd_ready_o);
  assert_clear_blocks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_req_i |-> !cmd_ready_o);
  assert_err_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_err_o |-> ($past(cmd_valid_i && cmd_ready_o) && !any_stb && $stable(bus_addr_o)));
  assert_err_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_err_o |-> ($past(cmd_dev_i) >= DEV_W'(NUM_DEV)));
  assert_no_overlap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(master_rst_o && any_stb));
endmodule

bind xpt_write_seq xpt_write_seq_chk #(
  .NUM_DEV    (NUM_DEV),
  .DEV_W      (DEV_W),
  .LINE_W     (LINE_W),
  .MASK_W     (MASK_W),
  .STROBE_CYC (STROBE_CYC),
  .CLEAR_CYC  (CLEAR_CYC)
) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .clr_req_i    (clr_req_i),
  .cmd_valid_i  (cmd_valid_i),
  .cmd_ready_o  (cmd_ready_o),
  .cmd_dev_i    (cmd_dev_i),
  .bus_addr_o   (bus_addr_o),
  .bus_data_o   (bus_data_o),
  .dev_strobe_o (dev_strobe_o),
  .master_rst_o (master_rst_o),
  .cmd_err_o    (cmd_err_o)
);

// File: tb/xpt_write_seq_tb_top.sv
`timescale 1ns/100ps
module xpt_write_seq_tb_top;
  localparam int NUM_DEV = 4, DEV_W = 3, LINE_W = 3, MASK_W = 4;
  localparam int S = 2, P = 3, H = 2, C = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic clr = 1'b0, valid = 1'b0;
  logic [DEV_W-1:0]   dev  = '0;
  logic [LINE_W-1:0]  line = '0;
  logic [MASK_W-1:0]  mask = '0;
  logic               ready, mrst, err;
  logic [LINE_W-1:0]  addr;
  logic [MASK_W-1:0]  data;
  logic [NUM_DEV-1:0] stb;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  xpt_write_seq #(
    .NUM_DEV(NUM_DEV), .DEV_W(DEV_W), .LINE_W(LINE_W), .MASK_W(MASK_W),
    .SETUP_CYC(S), .STROBE_CYC(P), .HOLD_CYC(H), .CLEAR_CYC(C)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .clr_req_i(clr), .cmd_valid_i(valid),
    .cmd_ready_o(ready), .cmd_dev_i(dev), .cmd_line_i(line), .cmd_mask_i(mask),
    .bus_addr_o(addr), .bus_data_o(data), .dev_strobe_o(stb),
    .master_rst_o(mrst), .cmd_err_o(err)
  );

  // reference model: 0 idle, 1 setup, 2 strobe, 3 hold, 4 clear
  int m_mode = 0, m_rem = 0, m_dev = 0;
  logic [LINE_W-1:0] m_addr = '0;
  logic [MASK_W-1:0] m_data = '0;
  logic m_err = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_rem = 0; m_dev = 0; m_addr = '0; m_data = '0; m_err = 1'b0;
    end else begin
      m_err = 1'b0;
      case (m_mode)
        0: if (clr) begin m_mode = 4; m_rem = C; end
           else if (valid) begin
             if (int'(dev) < NUM_DEV) begin
               m_mode = 1; m_rem = S; m_dev = int'(dev); m_addr = line; m_data = mask;
             end else m_err = 1'b1;
           end
        1: if (m_rem == 1) begin m_mode = 2; m_rem = P; end else m_rem--;
        2: if (m_rem == 1) begin m_mode = 3; m_rem = H; end else m_rem--;
        default: if (m_rem == 1) m_mode = 0; else m_rem--;
      endcase
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(clr ? "R7 ready while clear requested" : "R2 ready", 32'(ready),
          32'(m_mode == 0 && !clr));
      chk("R4 strobes", 32'(stb), (m_mode == 2) ? (32'd1 << m_dev) : 32'd0);
      chk("R6 master reset", 32'(mrst), 32'(m_mode == 4));
      chk("R8 error pulse", 32'(err), 32'(m_err));
      chk((m_mode == 3) ? "R5 address in hold" : "R3 address", 32'(addr), 32'(m_addr));
      chk((m_mode == 3) ? "R5 data in hold" : "R3 data", 32'(data), 32'(m_data));
      chk("R9 reset and strobe exclusive", 32'(mrst && (stb != '0)), 32'd0);
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic wait_idle();
    while (!ready) step();
  endtask

  task automatic wr(input int d, input int l, input int m);
    dev = DEV_W'(d); line = LINE_W'(l); mask = MASK_W'(m); valid = 1'b1;
    #0.1;
    while (!ready) step();
    step();
    valid = 1'b0;
  endtask

  task automatic clear_op();
    clr = 1'b1;
    while (!mrst) step();
    clr = 1'b0;
    wait_idle();
  endtask

  initial begin
    #1;
    // R1: during reset
    chk("R1 ready in reset", 32'(ready), 32'd1);
    chk("R1 strobes in reset", 32'(stb), 32'd0);
    chk("R1 reset line", 32'(mrst), 32'd0);
    chk("R1 error", 32'(err), 32'd0);
    chk("R1 bus", 32'({addr, data}), 32'd0);
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk("R1 idle after release", 32'(ready), 32'd1);

    // R4: single writes, distinct patterns
    wr(0, 3, 4'b0101); wait_idle();
    wr(3, 7, 4'b1111); wait_idle();
    wr(1, 0, 4'b0000); wait_idle();
    // R2: back-to-back with valid held
    wr(2, 5, 4'b1010); wr(1, 6, 4'b0011); wait_idle();

    // R8: out-of-range indices
    dev = 3'd6; line = 3'd2; mask = 4'b1001; valid = 1'b1;
    step(); valid = 1'b0;
    chk("R8 error seen", 32'(err), 32'd1);
    chk("R8 no strobe", 32'(stb), 32'd0);
    chk("R8 ready stays high", 32'(ready), 32'd1);
    wr(7, 1, 4'b1100); step();

    // R6: plain clear
    clear_op();

    // R7: clear raised during a write, second write also pending
    wr(2, 4, 4'b0110);
    dev = 3'd3; line = 3'd1; mask = 4'b1110; valid = 1'b1; clr = 1'b1;
    while (!mrst) step();
    chk("R7 clear served before pending write", 32'(stb), 32'd0);
    clr = 1'b0;
    while (!ready) step();
    step(); valid = 1'b0;
    wait_idle();

    // R7: clear and write arrive together in idle
    dev = 3'd0; line = 3'd7; mask = 4'b0001; valid = 1'b1; clr = 1'b1;
    #0.1;
    chk("R7 ready low with clear", 32'(ready), 32'd0);
    while (!mrst) step();
    clr = 1'b0;
    while (!ready) step();
    step(); valid = 1'b0;
    wait_idle();
    repeat (3) step();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    done = 1;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule